// File: doc/BRIEF.md
# Test-access instruction register with decode

This block holds the instruction of a boundary-scan test port. A separate test-port state machine supplies one-cycle state strobes: capture, shift and update for the instruction path, capture and shift for the data path, and test-logic-reset. The block uses these strobes to run a 3-bit instruction shift register between serial in and serial out. It moves the shifted value into a parallel instruction latch on the falling test-clock edge, and it decodes the latched instruction.

The decode has two results. The first is a one-hot select of the data register that sits in the serial path: the one-bit bypass register, the identification register or the boundary scan chain. The second is the control for the chip's output pins: drive them from the scan cells, hold them (clamp) or float them. The block also contains the bypass bit and the serial-out multiplexer. The multiplexer is retimed to the falling edge and comes with a valid flag.

Top module: `tap_instr_reg`

## Requirements
- R1: A capture-IR strobe loads the shift register with 001, so its two low bits are 01. Each rising test-clock edge under shift-IR moves the register one place toward serial out: bit 0 leaves first and serial in enters bit 2.
- R2: The parallel instruction takes the shift register contents on the falling test-clock edge of a cycle in which the update-IR strobe is high. At all other times it keeps its value.
- R3: Test-logic-reset (on a falling edge) and the asynchronous reset both force the instruction to 001 (IDCODE). Test-logic-reset takes priority over update-IR.
- R4: The register select is one-hot over {sel_bscan, sel_ident, sel_bypass}. Codes 000 (EXTEST) and 010 (SAMPLE/PRELOAD) pick the boundary chain. Code 001 picks identification. Codes 011 (CLAMP), 100 (HIGHZ) and 111 (BYPASS) pick bypass.
- R5: Codes 101 and 110 decode exactly as 111: bypass selected and no pin control asserted.
- R6: pin_scan_drive is high for 000 and 011. pin_hold is high only for 011. pin_hiz is high only for 100. For every other code all three are low.
- R7: sdo and sdo_valid change on the falling test-clock edge. sdo_valid is 1 exactly when shift-IR or shift-DR was high at that edge. At any other edge sdo is 0.
- R8: Under shift-IR, sdo presents shift register bit 0. Under shift-DR, sdo presents the selected source: the bypass bit, ident_sdo or bscan_sdo.
- R9: The bypass bit clears on a capture-DR rising edge and loads sdi on a shift-DR rising edge, so in bypass the data stream is delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_tlr | input | 1 | Test-logic-reset state strobe |
| st_capture_ir | input | 1 | Capture-IR state strobe |
| st_shift_ir | input | 1 | Shift-IR state strobe |
| st_update_ir | input | 1 | Update-IR state strobe |
| st_capture_dr | input | 1 | Capture-DR state strobe |
| st_shift_dr | input | 1 | Shift-DR state strobe |
| sdi | input | 1 | Serial test data in |
| ident_sdo | input | 1 | Serial output of the identification register |
| bscan_sdo | input | 1 | Serial output of the boundary scan chain |
| instr | output | IR_W | Latched parallel instruction |
| sel_bypass | output | 1 | Bypass register selected |
| sel_ident | output | 1 | Identification register selected |
| sel_bscan | output | 1 | Boundary scan chain selected |
| pin_scan_drive | output | 1 | Output pins take values from the scan cells |
| pin_hold | output | 1 | Scan-driven pin values must stay frozen (clamp) |
| pin_hiz | output | 1 | All output enables off |
| sdo | output | 1 | Serial test data out, falling-edge timed |
| sdo_valid | output | 1 | sdo carries shift data |

## Verification
The bench builds the block with its default parameters: a 3-bit register, the six standard codes, capture pattern 001, and the falling-edge variants of both the update latch and serial out. With these values all eight 3-bit codes can be reached, so the two unlisted codes are loaded and checked as well as the six listed ones. The bench also covers a short 2-bit instruction shift, an update with no shift at all, test-logic-reset arriving mid-run, and an asynchronous reset after a non-default instruction. Each scan pattern is checked against a queue-based model on every clock, including the one-cycle delay through the bypass bit.

// File: rtl/tap_ir_pkg.sv
package tap_ir_pkg;

   typedef enum logic [1:0] {
      DR_BYPASS = 2'd0,
      DR_IDENT  = 2'd1,
      DR_BSCAN  = 2'd2
   } dr_sel_e;

   typedef struct packed {
      logic scan_drive;
      logic hold;
      logic hiz;
   } pin_ctl_t;

endpackage

// File: rtl/tap_ir_shift.sv
module tap_ir_shift #(
   parameter int              W       = 3,
   parameter logic [W-1:0]    CAP_PAT = W'(1)
) (
   input  logic         tck,
   input  logic         rst_n,
   input  logic         cap,
   input  logic         shf,
   input  logic         sdi,
   output logic [W-1:0] q
);
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)   q <= CAP_PAT;
      else if (cap) q <= CAP_PAT;
      else if (shf) q <= {sdi, q[W-1:1]};
   end
endmodule

// File: rtl/tap_ir_hold.sv
module tap_ir_hold #(
   parameter int           W        = 3,
   parameter logic [W-1:0] RST_CODE = W'(1),
   parameter bit           ON_FALL  = 1'b1
) (
   input  logic         tck,
   input  logic         rst_n,
   input  logic         tlr,
   input  logic         upd,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = q;
      if (tlr)      nxt = RST_CODE;
      else if (upd) nxt = d;
   end

   generate
      if (ON_FALL) begin : g_fall
         always_ff @(negedge tck or negedge rst_n) begin
            if (!rst_n) q <= RST_CODE;
            else        q <= nxt;
         end
      end else begin : g_rise
         always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n) q <= RST_CODE;
            else        q <= nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/tap_ir_decode_logic.sv
module tap_ir_decode_logic
   import tap_ir_pkg::*;
#(
   parameter int           W           = 3,
   parameter logic [W-1:0] CODE_EXTEST = '0,
   parameter logic [W-1:0] CODE_IDCODE = W'(1),
   parameter logic [W-1:0] CODE_SAMPLE = W'(2),
   parameter logic [W-1:0] CODE_CLAMP  = W'(3),
   parameter logic [W-1:0] CODE_HIGHZ  = W'(4),
   parameter logic [W-1:0] CODE_BYPASS = '1
) (
   input  logic [W-1:0] instr,
   output dr_sel_e      sel,
   output pin_ctl_t     pins
);
   always_comb begin
      sel  = DR_BYPASS;
      pins = '0;
      case (instr)
         CODE_EXTEST: begin
            sel             = DR_BSCAN;
            pins.scan_drive = 1'b1;
         end
         CODE_SAMPLE: sel = DR_BSCAN;
         CODE_IDCODE: sel = DR_IDENT;
         CODE_CLAMP: begin
            pins.scan_drive = 1'b1;
            pins.hold       = 1'b1;
         end
         CODE_HIGHZ:  pins.hiz = 1'b1;
         CODE_BYPASS: sel = DR_BYPASS;
         default:     sel = DR_BYPASS;
      endcase
   end
endmodule

// File: rtl/tap_dr_out.sv
module tap_dr_out
   import tap_ir_pkg::*;
#(
   parameter bit ON_FALL = 1'b1
) (
   input  logic    tck,
   input  logic    rst_n,
   input  logic    cap_dr,
   input  logic    shf_dr,
   input  logic    shf_ir,
   input  logic    sdi,
   input  logic    ir_lsb,
   input  dr_sel_e sel,
   input  logic    ident_sdo,
   input  logic    bscan_sdo,
   output logic    byp_q,
   output logic    sdo,
   output logic    sdo_valid
);
   logic nxt_sdo, nxt_val;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      byp_q <= 1'b0;
      else if (cap_dr) byp_q <= 1'b0;
      else if (shf_dr) byp_q <= sdi;
   end

   always_comb begin
      nxt_sdo = 1'b0;
      nxt_val = 1'b0;
      if (shf_ir) begin
         nxt_sdo = ir_lsb;
         nxt_val = 1'b1;
      end else if (shf_dr) begin
         nxt_val = 1'b1;
         case (sel)
            DR_IDENT: nxt_sdo = ident_sdo;
            DR_BSCAN: nxt_sdo = bscan_sdo;
            default:  nxt_sdo = byp_q;
         endcase
      end
   end

   generate
      if (ON_FALL) begin : g_fall
         always_ff @(negedge tck or negedge rst_n) begin
            if (!rst_n) begin
               sdo       <= 1'b0;
               sdo_valid <= 1'b0;
            end else begin
               sdo       <= nxt_sdo;
               sdo_valid <= nxt_val;
            end
         end
      end else begin : g_rise
         always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n) begin
               sdo       <= 1'b0;
               sdo_valid <= 1'b0;
            end else begin
               sdo       <= nxt_sdo;
               sdo_valid <= nxt_val;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
   import tap_ir_pkg::*;
#(
   parameter int              IR_W           = 3,
   parameter logic [IR_W-1:0] CODE_EXTEST    = '0,
   parameter logic [IR_W-1:0] CODE_IDCODE    = IR_W'(1),
   parameter logic [IR_W-1:0] CODE_SAMPLE    = IR_W'(2),
   parameter logic [IR_W-1:0] CODE_CLAMP     = IR_W'(3),
   parameter logic [IR_W-1:0] CODE_HIGHZ     = IR_W'(4),
   parameter logic [IR_W-1:0] CODE_BYPASS    = '1,
   parameter logic [IR_W-1:0] CAPTURE_PAT    = IR_W'(1),
   parameter bit              UPDATE_ON_FALL = 1'b1,
   parameter bit              SDO_ON_FALL    = 1'b1
) (
   input  logic            tck,
   input  logic            rst_n,
   input  logic            st_tlr,
   input  logic            st_capture_ir,
   input  logic            st_shift_ir,
   input  logic            st_update_ir,
   input  logic            st_capture_dr,
   input  logic            st_shift_dr,
   input  logic            sdi,
   input  logic            ident_sdo,
   input  logic            bscan_sdo,
   output logic [IR_W-1:0] instr,
   output logic            sel_bypass,
   output logic            sel_ident,
   output logic            sel_bscan,
   output logic            pin_scan_drive,
   output logic            pin_hold,
   output logic            pin_hiz,
   output logic            sdo,
   output logic            sdo_valid
);
   generate
      if (IR_W < 2) begin : g_bad_width
         $error("tap_instr_reg: IR_W must be at least 2");
      end
      if (CAPTURE_PAT[1:0] != 2'b01) begin : g_bad_pattern
         $error("tap_instr_reg: capture pattern must end in 01");
      end
   endgenerate

   logic [IR_W-1:0] shift_q;
   logic            byp_q;
   dr_sel_e         sel;
   pin_ctl_t        pins;

   tap_ir_shift #(.W(IR_W), .CAP_PAT(CAPTURE_PAT)) u_shift (
      .tck(tck), .rst_n(rst_n), .cap(st_capture_ir), .shf(st_shift_ir),
      .sdi(sdi), .q(shift_q)
   );

   tap_ir_hold #(.W(IR_W), .RST_CODE(CODE_IDCODE), .ON_FALL(UPDATE_ON_FALL)) u_hold (
      .tck(tck), .rst_n(rst_n), .tlr(st_tlr), .upd(st_update_ir),
      .d(shift_q), .q(instr)
   );

   tap_ir_decode_logic #(
      .W(IR_W), .CODE_EXTEST(CODE_EXTEST), .CODE_IDCODE(CODE_IDCODE),
      .CODE_SAMPLE(CODE_SAMPLE), .CODE_CLAMP(CODE_CLAMP),
      .CODE_HIGHZ(CODE_HIGHZ), .CODE_BYPASS(CODE_BYPASS)
   ) u_dec (
      .instr(instr), .sel(sel), .pins(pins)
   );

   tap_dr_out #(.ON_FALL(SDO_ON_FALL)) u_out (
      .tck(tck), .rst_n(rst_n), .cap_dr(st_capture_dr), .shf_dr(st_shift_dr),
      .shf_ir(st_shift_ir), .sdi(sdi), .ir_lsb(shift_q[0]), .sel(sel),
      .ident_sdo(ident_sdo), .bscan_sdo(bscan_sdo), .byp_q(byp_q),
      .sdo(sdo), .sdo_valid(sdo_valid)
   );

   assign sel_bypass     = (sel == DR_BYPASS);
   assign sel_ident      = (sel == DR_IDENT);
   assign sel_bscan      = (sel == DR_BSCAN);
   assign pin_scan_drive = pins.scan_drive;
   assign pin_hold       = pins.hold;
   assign pin_hiz        = pins.hiz;
endmodule

// File: rtl/tap_instr_reg_chk.sv
module tap_instr_reg_chk #(
   parameter int              IR_W        = 3,
   parameter logic [IR_W-1:0] CODE_IDCODE = IR_W'(1)
) (
   input logic            tck,
   input logic            rst_n,
   input logic            st_tlr,
   input logic            st_capture_ir,
   input logic            st_shift_ir,
   input logic            st_update_ir,
   input logic            st_shift_dr,
   input logic            sdi,
   input logic [IR_W-1:0] shift_q,
   input logic [IR_W-1:0] instr,
   input logic            sel_bypass,
   input logic            sel_ident,
   input logic            sel_bscan,
   input logic            pin_scan_drive,
   input logic            pin_hold,
   input logic            pin_hiz,
   input logic            sdo_valid,
   input logic            byp_q
);
   // R1: capture leaves 01 in the low bits
   a_r1_capture_low_bits: assert property (@(posedge tck) disable iff (!rst_n)
      st_capture_ir |=> shift_q[1:0] == 2'b01);

   // R2: falling-edge transfer of the shifted value
   a_r2_update_takes_shift: assert property (@(negedge tck) disable iff (!rst_n)
      (st_update_ir && !st_tlr) |=> instr == $past(shift_q));

   // R3: test-logic-reset forces the identification code
   a_r3_tlr_forces_ident: assert property (@(negedge tck) disable iff (!rst_n)
      st_tlr |=> instr == CODE_IDCODE);

   // R4: exactly one data register selected
   a_r4_one_select: assert property (@(posedge tck) disable iff (!rst_n)
      $countones({sel_bypass, sel_ident, sel_bscan}) == 1);

   // R6: clamp implies scan drive, float excludes scan drive
   a_r6_hold_needs_drive: assert property (@(posedge tck) disable iff (!rst_n)
      pin_hold |-> pin_scan_drive);
   a_r6_hiz_no_drive: assert property (@(posedge tck) disable iff (!rst_n)
      pin_hiz |-> (!pin_scan_drive && sel_bypass));

   // R7: no valid flag outside shift states
   a_r7_valid_only_shift: assert property (@(negedge tck) disable iff (!rst_n)
      !(st_shift_ir || st_shift_dr) |=> !sdo_valid);

   // R9: bypass bit follows sdi by one clock
   a_r9_bypass_delay: assert property (@(posedge tck) disable iff (!rst_n)
      st_shift_dr |=> byp_q == $past(sdi));
endmodule

bind tap_instr_reg tap_instr_reg_chk #(.IR_W(IR_W), .CODE_IDCODE(CODE_IDCODE)) u_chk (.*);

// File: tb/tap_instr_reg_test.sv
`timescale 1ns/1ps
module tap_instr_reg_test;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, tlr, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, sdi, id_in, bs_in;
   logic [2:0] instr;
   logic sel_bypass, sel_ident, sel_bscan, pin_scan_drive, pin_hold, pin_hiz, sdo, sdo_valid;

   tap_instr_reg uut (
      .tck(clk), .rst_n(rst_n), .st_tlr(tlr), .st_capture_ir(cap_ir),
      .st_shift_ir(sh_ir), .st_update_ir(upd_ir), .st_capture_dr(cap_dr),
      .st_shift_dr(sh_dr), .sdi(sdi), .ident_sdo(id_in), .bscan_sdo(bs_in),
      .instr(instr), .sel_bypass(sel_bypass), .sel_ident(sel_ident),
      .sel_bscan(sel_bscan), .pin_scan_drive(pin_scan_drive), .pin_hold(pin_hold),
      .pin_hiz(pin_hiz), .sdo(sdo), .sdo_valid(sdo_valid)
   );

   int checks = 0;
   int errors = 0;
   int ncyc   = 0;
   bit done   = 0;

   // reference model state
   int   m_ir[$];
   int   m_instr;
   int   m_byp;
   int   e_sdo, e_val;

   localparam int S_NONE = 0, S_TLR = 1, S_CIR = 2, S_SIR = 3, S_UIR = 4, S_CDR = 5, S_SDR = 6;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // spec tables (R4, R5, R6): 2 = boundary, 1 = ident, 0 = bypass
   function automatic int want_sel(input int c);
      if (c == 0 || c == 2) return 2;
      if (c == 1) return 1;
      return 0;
   endfunction

   function automatic int want_pins(input int c);
      // bit2 scan_drive, bit1 hold, bit0 hiz
      if (c == 0) return 4;
      if (c == 3) return 6;
      if (c == 4) return 1;
      return 0;
   endfunction

   task automatic model_reset();
      m_ir = '{1, 0, 0};
      m_instr = 1;
      m_byp = 0;
      e_sdo = 0;
      e_val = 0;
   endtask

   task automatic model_fall();
      int nxt;
      nxt = m_instr;
      if (tlr) nxt = 1;
      else if (upd_ir) nxt = m_ir[0] + 2 * m_ir[1] + 4 * m_ir[2];
      if (sh_ir) begin
         e_val = 1; e_sdo = m_ir[0];
      end else if (sh_dr) begin
         e_val = 1;
         case (want_sel(m_instr))
            1: e_sdo = int'(id_in);
            2: e_sdo = int'(bs_in);
            default: e_sdo = m_byp;
         endcase
      end else begin
         e_val = 0; e_sdo = 0;
      end
      m_instr = nxt;
   endtask

   task automatic model_rise();
      if (cap_ir) m_ir = '{1, 0, 0};
      else if (sh_ir) begin
         void'(m_ir.pop_front());
         m_ir.push_back(int'(sdi));
      end
      if (cap_dr) m_byp = 0;
      else if (sh_dr) m_byp = int'(sdi);
   endtask

   task automatic compare();
      int s, p;
      s = want_sel(m_instr);
      p = want_pins(m_instr);
      chk(int'(instr) == m_instr, "R2 R3 instr", int'(instr), m_instr);
      chk({sel_bscan, sel_ident, sel_bypass} == 3'(1 << s), "R4 R5 select",
          int'({sel_bscan, sel_ident, sel_bypass}), 1 << s);
      chk(int'({pin_scan_drive, pin_hold, pin_hiz}) == p, "R6 pins",
          int'({pin_scan_drive, pin_hold, pin_hiz}), p);
      chk(int'(sdo_valid) == e_val, "R7 sdo_valid", int'(sdo_valid), e_val);
      chk(int'(sdo) == e_sdo, "R1 R8 R9 sdo", int'(sdo), e_sdo);
   endtask

   task automatic cyc(input int st, input bit d);
      tlr    = (st == S_TLR);
      cap_ir = (st == S_CIR);
      sh_ir  = (st == S_SIR);
      upd_ir = (st == S_UIR);
      cap_dr = (st == S_CDR);
      sh_dr  = (st == S_SDR);
      sdi    = d;
      id_in  = ncyc[0];
      bs_in  = ncyc[1] ^ ncyc[3];
      ncyc++;
      model_fall();
      @(negedge clk); #8;
      compare();
      @(posedge clk);
      model_rise();
      #2;
   endtask

   task automatic load_ir(input logic [2:0] code, input int nbits);
      cyc(S_CIR, 1'b0);
      for (int i = 0; i < nbits; i++) cyc(S_SIR, code[i]);
      cyc(S_NONE, 1'b0);
      cyc(S_UIR, 1'b0);
      cyc(S_NONE, 1'b0);
   endtask

   task automatic dr_scan(input int n, input int seed);
      cyc(S_CDR, 1'b0);
      for (int i = 0; i < n; i++) cyc(S_SDR, 1'((seed >> (i % 8)) ^ i));
      cyc(S_NONE, 1'b0);
   endtask

   initial begin
      rst_n = 1'b0;
      {tlr, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, sdi, id_in, bs_in} = '0;
      model_reset();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // reset state (R3)
      chk(instr == 3'b001, "R3 reset instr", int'(instr), 1);
      chk(sel_ident == 1'b1, "R4 reset select ident", int'(sel_ident), 1);
      chk(sdo_valid == 1'b0, "R7 reset sdo_valid", int'(sdo_valid), 0);
      cyc(S_NONE, 1'b0);
      dr_scan(6, 8'h5a);
      // every code, including unlisted 101 and 110 (R5)
      for (int c = 0; c < 8; c++) begin
         load_ir(3'(c), 3);
         dr_scan(7, c * 37 + 11);
      end
      // IR capture pattern shifted out without update (R1)
      cyc(S_CIR, 1'b1);
      for (int i = 0; i < 5; i++) cyc(S_SIR, 1'(i));
      cyc(S_NONE, 1'b0);
      // short 2-bit shift then update (R1, R2)
      load_ir(3'b111, 3);
      load_ir(3'b110, 2);
      dr_scan(4, 3);
      // update right after capture with no shift
      cyc(S_CIR, 1'b0);
      cyc(S_UIR, 1'b0);
      cyc(S_NONE, 1'b0);
      // test-logic-reset after HIGHZ (R3)
      load_ir(3'b100, 3);
      cyc(S_TLR, 1'b0);
      cyc(S_NONE, 1'b0);
      dr_scan(5, 9);
      // asynchronous reset after CLAMP (R3)
      load_ir(3'b011, 3);
      rst_n = 1'b0;
      #1;
      chk(instr == 3'b001, "R3 async reset instr", int'(instr), 1);
      chk(pin_hold == 1'b0, "R6 async reset hold", int'(pin_hold), 0);
      model_reset();
      @(posedge clk); #2 rst_n = 1'b1;
      load_ir(3'b010, 3);
      dr_scan(6, 77);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule